// File: doc/BRIEF.md
# Programmable Format Async Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A six-bit line-control input chooses the character size (5 to 8 data bits), the stop period (one bit time, or a longer stop of one and a half or two bit times), and the parity mode. The parity mode is one of: none, odd, even, or a stuck parity bit whose value depends on the odd/even select.

Bit timing comes from an external enable that pulses at sixteen times the baud rate. Every bit lasts sixteen of these pulses. While the transmitter is idle it raises its ready flag. It accepts a character on the first clock where the valid strobe is high and ready is high. At that moment it captures both the data byte and the control value, and it keeps them for the whole frame. When the last stop tick has been consumed, it emits a one-cycle done pulse and returns to ready.

Top module: `fmt_async_tx`

## Requirements
- R1: After reset and whenever idle, the serial line is high, ready is high and done is low.
- R2: A frame is a low start bit, the data bits least significant first, the optional parity bit, and then a high stop period.
- R3: Control bits [1:0] give the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are never sent.
- R4: When control bit [2] is 0, the stop period is one bit time (16 ticks) for every length.
- R5: When control bit [2] is 1, the stop period is 24 ticks for 5-bit characters and 32 ticks for 6, 7 or 8 bits.
- R6: When control bit [3] is 0, no parity bit is sent.
- R7: When control bit [3] is 1 and bit [5] is 0, bit [4]=0 selects odd parity and bit [4]=1 selects even parity. Parity counts only the selected data bits.
- R8: When control bits [3] and [5] are both 1, the parity bit is 1 if bit [4] is 0 and 0 if bit [4] is 1.
- R9: Each start, data and parity bit lasts exactly 16 tick pulses. Clocks without a tick never advance the frame.
- R10: Data and control are captured at acceptance. Changes to them during the frame, and valid strobes while busy, have no effect.
- R11: Done is high for exactly one clock when the frame ends. Ready is high in that same clock and stays low from acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the baud rate |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Request to send tx_data |
| line_ctl | input | 6 | Frame format: length, stop, parity enable, even select, stick |
| tx_line | output | 1 | Serial output, idles high |
| tx_ready | output | 1 | High when a new character can be accepted |
| tx_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The bench targets the corners where format bits interact. The 1.5-bit stop appears only with 5-bit characters, so a design that applies two full stop bits there gives a frame 8 ticks too long. Parity is computed over masked data in which the unused upper bits are set. A design that counts all eight bits then sends the wrong parity, and one that confuses stick polarity inverts it. The bench also changes control and data in mid-frame, strobes valid while busy, and spaces ticks unevenly. A design that reads live inputs, accepts a second request, or counts clocks instead of ticks produces a corrupt frame, starts an extra one, or shows a wrong frame length.

// File: rtl/fatx_pkg.sv
package fatx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    // Field order matches the control word: [5] stick, [4] even, [3] parity on,
    // [2] long stop, [1:0] length select.
    typedef struct packed {
        logic       par_stick;
        logic       par_even;
        logic       par_en;
        logic       long_stop;
        logic [1:0] len_sel;
    } line_fmt_t;

endpackage

// File: rtl/fatx_fmt_decode.sv
module fatx_fmt_decode
    import fatx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int DB_W = $clog2(DATA_W + 1),
    parameter int CNT_W = $clog2(2 * TICKS_PER_BIT + 1)
) (
    input  line_fmt_t          fmt,
    output logic [DB_W-1:0]    data_bits,
    output logic [CNT_W-1:0]   stop_ticks
);
    localparam int MIN_BITS  = DATA_W - 3;
    localparam int HALF_STOP = TICKS_PER_BIT + TICKS_PER_BIT / 2;
    localparam int FULL_STOP = 2 * TICKS_PER_BIT;

    always_comb begin
        data_bits = DB_W'(MIN_BITS) + DB_W'(fmt.len_sel);
        if (!fmt.long_stop) begin
            stop_ticks = CNT_W'(TICKS_PER_BIT);
        end else if (fmt.len_sel == 2'b00) begin
            stop_ticks = CNT_W'(HALF_STOP);
        end else begin
            stop_ticks = CNT_W'(FULL_STOP);
        end
    end

    always_comb begin
        assert_stop_range_R5: assert (stop_ticks >= CNT_W'(TICKS_PER_BIT)
                                      && stop_ticks <= CNT_W'(FULL_STOP));
    end
endmodule

// File: rtl/fatx_parity.sv
module fatx_parity
    import fatx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DB_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DB_W-1:0]   data_bits,
    input  line_fmt_t         fmt,
    output logic              par_bit
);
    logic [DATA_W-1:0] used;
    logic              ones_odd;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign used[g] = data[g] & (DB_W'(g) < data_bits);
    end

    always_comb begin
        ones_odd = ^used;
        if (fmt.par_stick) begin
            par_bit = ~fmt.par_even;
        end else if (fmt.par_even) begin
            par_bit = ones_odd;
        end else begin
            par_bit = ~ones_odd;
        end
    end
endmodule

// File: rtl/fatx_bit_timer.sv
module fatx_bit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             bit_end
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_last;

    always_comb begin
        at_last = (cnt_q == limit - CNT_W'(1));
        bit_end = tick && at_last && !clear;
        cnt_d   = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> cnt_q < limit);

    assert_cnt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/fmt_async_tx.sv
module fmt_async_tx
    import fatx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTL_W = 6,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic [CTL_W-1:0]  line_ctl,
    output logic              tx_line,
    output logic              tx_ready,
    output logic              tx_done
);
    localparam int DB_W  = $clog2(DATA_W + 1);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

    typedef struct packed {
        tx_state_e         state;
        line_fmt_t         fmt;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  idx;
        logic              line;
        logic              done;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    logic [DB_W-1:0]  data_bits;
    logic [CNT_W-1:0] stop_ticks;
    logic [CNT_W-1:0] tmr_limit;
    logic             par_bit;
    logic             bit_end;
    logic             tmr_clear;
    logic             last_data;
    logic [IDX_W-1:0] idx_next;

    fatx_fmt_decode #(
        .DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT), .DB_W(DB_W), .CNT_W(CNT_W)
    ) u_decode (
        .fmt        (r_q.fmt),
        .data_bits  (data_bits),
        .stop_ticks (stop_ticks)
    );

    fatx_parity #(.DATA_W(DATA_W), .DB_W(DB_W)) u_parity (
        .data      (r_q.data),
        .data_bits (data_bits),
        .fmt       (r_q.fmt),
        .par_bit   (par_bit)
    );

    fatx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .tick    (tick16),
        .limit   (tmr_limit),
        .bit_end (bit_end)
    );

    always_comb begin
        tmr_clear = (r_q.state == ST_IDLE);
        tmr_limit = (r_q.state == ST_STOP) ? stop_ticks : CNT_W'(TICKS_PER_BIT);
        last_data = (DB_W'(r_q.idx) == data_bits - DB_W'(1));
        idx_next  = r_q.idx + IDX_W'(1);

        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.line = 1'b1;
                if (tx_valid) begin
                    r_d.state = ST_START;
                    r_d.fmt   = line_fmt_t'(line_ctl);
                    r_d.data  = tx_data;
                    r_d.idx   = '0;
                    r_d.line  = 1'b0;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    r_d.state = ST_DATA;
                    r_d.idx   = '0;
                    r_d.line  = r_q.data[0];
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (!last_data) begin
                        r_d.idx  = idx_next;
                        r_d.line = r_q.data[idx_next];
                    end else if (r_q.fmt.par_en) begin
                        r_d.state = ST_PAR;
                        r_d.line  = par_bit;
                    end else begin
                        r_d.state = ST_STOP;
                        r_d.line  = 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (bit_end) begin
                    r_d.state = ST_STOP;
                    r_d.line  = 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.line  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.line  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_line  = r_q.line;
    assign tx_ready = (r_q.state == ST_IDLE);
    assign tx_done  = r_q.done;

    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_line);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> !tx_line);

    assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STOP) |-> tx_line);

    assert_no_parity_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.fmt.par_en |-> r_q.state != ST_PAR);

    assert_stick_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PAR && r_q.fmt.par_stick) |-> tx_line == ~r_q.fmt.par_even);

    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !tick16) |=> $stable(tx_line) && !tx_done);

    assert_format_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !$past(tx_ready)) |-> $stable(r_q.fmt) && $stable(r_q.data));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_done_with_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_ready && $past(!tx_ready));
endmodule

// File: tb/sim_fmt_async_tx.sv
`timescale 1ns/1ps
module sim_fmt_async_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic [5:0] line_ctl = '0;
    logic       tx_line, tx_ready, tx_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    fmt_async_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_data(tx_data),
        .tx_valid(tx_valid), .line_ctl(line_ctl), .tx_line(tx_line),
        .tx_ready(tx_ready), .tx_done(tx_done)
    );

    always #4 clk = ~clk;

    // {control, data}
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        {6'h00, 8'hE5}, {6'h01, 8'h96}, {6'h02, 8'h4B}, {6'h03, 8'hA5},
        {6'h04, 8'h13}, {6'h05, 8'h2A}, {6'h07, 8'h81}, {6'h0B, 8'h55},
        {6'h1B, 8'h55}, {6'h18, 8'hF1}, {6'h08, 8'hE0}, {6'h2B, 8'h00},
        {6'h3C, 8'hFF}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [5:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic exp_par(input logic [5:0] c, input logic [7:0] d);
        logic ones = 1'b0;
        for (int i = 0; i < nbits(c); i++) ones ^= d[i];
        if (c[5]) return ~c[4];
        return c[4] ? ones : ~ones;
    endfunction

    function automatic int exp_ticks(input logic [5:0] c);
        int stop = 16;
        if (c[2]) stop = (c[1:0] == 2'b00) ? 24 : 32;
        return 16 * (1 + nbits(c) + int'(c[3])) + stop;
    endfunction

    function automatic logic exp_bit(input logic [5:0] c, input logic [7:0] d, input int k);
        int n = nbits(c);
        if (k == 0) return 1'b0;
        if (k <= n) return d[k-1];
        if (c[3] && k == n + 1) return exp_par(c, d);
        return 1'b1;
    endfunction

    // mode 0 plain, 1 inputs disturbed mid-frame, 2 valid strobed while busy
    task automatic send(input logic [5:0] c, input logic [7:0] d, input int period,
                        input int mode, input string req);
        int tck = 0;
        int phase = 0;
        int bad_bits = 0;
        int busy_bad = 0;
        bit done_seen = 0;
        bit tk;
        @(negedge clk);
        tick16 = 0;
        check(tx_ready, "R11 ready before request", tx_ready, 1);
        tx_valid = 1; tx_data = d; line_ctl = c;
        @(negedge clk);
        tx_valid = 0;
        if (mode == 1) begin line_ctl = ~c; tx_data = ~d; end
        while (!done_seen) begin
            if (tx_done) begin
                done_seen = 1;
            end else begin
                if (tx_ready) busy_bad++;
                tk = (phase == period - 1);
                phase = (phase + 1) % period;
                tick16 = tk;
                if (tk && (tck % 16) == 8) begin
                    if (tx_line !== exp_bit(c, d, tck / 16)) bad_bits++;
                end
                if (mode == 2) tx_valid = (tck == 40);
                if (mode == 2 && tck == 40) tx_data = 8'h3C;
                @(posedge clk);
                if (tk) tck++;
                @(negedge clk);
            end
        end
        tick16 = 0; tx_valid = 0; line_ctl = c;
        check(bad_bits == 0, {req, " frame bits"}, bad_bits, 0);
        check(tck == exp_ticks(c), {req, " R9 frame length in ticks"}, tck, exp_ticks(c));
        check(busy_bad == 0, "R11 ready low while busy", busy_bad, 0);
        check(tx_ready === 1'b1, "R11 ready with done", tx_ready, 1);
        @(negedge clk);
        check(tx_done === 1'b0, "R11 done is one cycle", tx_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(tx_line === 1'b1, "R1 line after reset", tx_line, 1);
        check(tx_ready === 1'b1, "R1 ready after reset", tx_ready, 1);
        check(tx_done === 1'b0, "R1 done after reset", tx_done, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(tx_line === 1'b1 && tx_ready === 1'b1, "R1 idle after release", tx_line, 1);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][13:8], VEC[i][7:0], 4, 0, "R2_R3_R4_R5_R6_R7_R8 vector");
        end

        // R5: 1.5 stop on 5 bits with parity, uneven tick spacing
        send(6'h0C, 8'hFE, 7, 0, "R5 half stop, R9 spacing 7");
        // R7: even parity, only low 6 bits counted
        send(6'h19, 8'hC1, 3, 0, "R7 masked parity");
        // R10: live inputs change during frame
        send(6'h3E, 8'h6D, 4, 1, "R10 inputs changed mid-frame");
        // R10: valid while busy must not queue a second frame
        send(6'h03, 8'h5A, 4, 2, "R10 valid while busy");
        begin
            int stray = 0;
            for (int j = 0; j < 80; j++) begin
                @(negedge clk);
                tick16 = (j % 2 == 0);
                if (tx_line !== 1'b1 || tx_ready !== 1'b1) stray++;
            end
            tick16 = 0;
            check(stray == 0, "R10 no frame after busy strobe", stray, 0);
        end
        // R9: no ticks, no progress
        @(negedge clk);
        tx_valid = 1; tx_data = 8'h00; line_ctl = 6'h03;
        @(negedge clk);
        tx_valid = 0;
        begin
            int moved = 0;
            for (int j = 0; j < 100; j++) begin
                @(negedge clk);
                if (tx_line !== 1'b0 || tx_done !== 1'b0) moved++;
            end
            check(moved == 0, "R9 frozen without ticks", moved, 0);
        end
        begin
            int guard = 0;
            while (!tx_done && guard < 5000) begin
                @(negedge clk);
                tick16 = ~tick16;
                guard++;
            end
            tick16 = 0;
            check(tx_done === 1'b1, "R11 frame completes after ticks resume", tx_done, 1);
        end
        repeat (2) @(negedge clk);
        // back-to-back: R3 8-bit then 5-bit
        send(6'h03, 8'hFF, 4, 0, "R3 back-to-back first");
        send(6'h00, 8'hFF, 4, 0, "R3 back-to-back second");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule